// File: doc/BRIEF.md
# Privilege-aware interrupt pending and priority selector

The block keeps one 64-bit pending vector for each of seven interrupt sources, plus a one-bit summary status for each source. Any agent in the core can raise a pending bit with a post request or drop one with a clear request. Each request names a source type and a bit index. A read port returns the whole vector of any one type.

On every cycle the block picks a winner from the registered pending state. It uses the current hypervisor-privilege input and the interrupt-enable input to do so. The result is a valid flag and an encoded interrupt kind. When the winner is a software interrupt, it also gives a 4-bit level.

In hypervisor mode, only the tick-match and interrupt-vector sources take part. Outside hypervisor mode, all seven sources take part in a fixed order. The lower four sources are gated by interrupt-enable. The software level comes from the software vector. Bit 0 and bit 16 both force the top level of 14. Otherwise the level is the highest set bit between 14 and 1.

Top module: `intr_pend_sel`

## Requirements
- R1: After reset, every pending vector and every status bit is zero, and `irq_valid`, `irq_kind` and `irq_level` are zero.
- R2: Type codes are: 0 trap-level-zero, 1 tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 software, 6 resumable error. A post with `post_type` 0..6 sets bit `post_idx` of that type's vector and sets `pend_stat[type]` at the next clock edge. `rd_vec` shows the vector of `rd_type` combinationally, and reads zero for `rd_type` 7.
- R3: A clear resets bit `clr_idx` of the named type's vector at the next edge. `pend_stat[type]` falls only when that type's whole vector becomes zero.
- R4: When a post and a clear name the same type and the same bit in one cycle, the bit ends up set.
- R5: A post or clear with type code 7 changes no vector and no status bit.
- R6: With `hpriv` = 1, only type 1 and type 2 can win. Type 1 ranks above type 2.
- R7: With `hpriv` = 0, the order is 0, 1, 2, 3, 4, 5, 6, with type 0 the highest.
- R8: Types 0, 1 and 2 win regardless of `ie`. In particular, a pending tick match wins under `hpriv` = 1 whatever `ie` is, and under `hpriv` = 0 it wins whenever type 0 is idle.
- R9: With `hpriv` = 0, types 3, 4, 5 and 6 are eligible only when `ie` = 1.
- R10: The software level is 14 when bit 0 or bit 16 of the software vector is set. Otherwise it is the index of the highest set bit in the range 14 down to 1.
- R11: A software vector with no set bit in 0..14 or 16 gets level 0 and is not eligible. In that case a pending resumable error can still win.
- R12: `irq_kind` carries the winner's type code. `irq_level` is nonzero only when the winner is type 5, and all selection outputs are zero when there is no winner. The selection is combinational from the registered pending state and the current `hpriv` and `ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | Post request strobe |
| post_type | input | 3 | Type code of the post |
| post_idx | input | 6 | Bit index of the post |
| clr_en | input | 1 | Clear request strobe |
| clr_type | input | 3 | Type code of the clear |
| clr_idx | input | 6 | Bit index of the clear |
| rd_type | input | 3 | Type whose vector is read |
| rd_vec | output | 64 | Pending vector of `rd_type` |
| pend_stat | output | 7 | Summary status bit per type |
| hpriv | input | 1 | Hypervisor-privileged mode |
| ie | input | 1 | Interrupt enable |
| irq_valid | output | 1 | A winner exists |
| irq_kind | output | 3 | Type code of the winner |
| irq_level | output | 4 | Software level when the winner is type 5 |

## Verification
The bench targets software vectors whose only set bits lie at 15 or above 16. A design that treated any set bit as eligible would wrongly report a software interrupt at level 0, hiding a resumable error. It also targets the aliasing bits 0 and 16, where a plain highest-bit scan would report the wrong level. Post and clear of one bit in one cycle would leave the bit clear if the order were reversed. Clearing one of two bits in a vector would drop the status bit too early if status followed the last clear rather than the whole vector. Random runs switch `hpriv` and `ie` often. A wrong gate would then let a mondo win while hypervisor-privileged or disabled, or would mask a tick match when interrupts are disabled.

// File: rtl/intr_pend_sel.sv
module intr_pend_sel #(
  parameter int NUM_TYPES = 7,
  parameter int VEC_W     = 64,
  parameter int SW_TOP    = 14,
  parameter int SW_ALIAS  = 16,
  parameter int LVL_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          post_en,
  input  logic [$clog2(NUM_TYPES+1)-1:0] post_type,
  input  logic [$clog2(VEC_W)-1:0]      post_idx,
  input  logic                          clr_en,
  input  logic [$clog2(NUM_TYPES+1)-1:0] clr_type,
  input  logic [$clog2(VEC_W)-1:0]      clr_idx,
  input  logic [$clog2(NUM_TYPES+1)-1:0] rd_type,
  output logic [VEC_W-1:0]              rd_vec,
  output logic [NUM_TYPES-1:0]          pend_stat,
  input  logic                          hpriv,
  input  logic                          ie,
  output logic                          irq_valid,
  output logic [$clog2(NUM_TYPES+1)-1:0] irq_kind,
  output logic [LVL_W-1:0]              irq_level
);
  localparam int TYPE_W = $clog2(NUM_TYPES + 1);
  localparam logic [TYPE_W-1:0] K_TL0  = TYPE_W'(0);
  localparam logic [TYPE_W-1:0] K_TICK = TYPE_W'(1);
  localparam logic [TYPE_W-1:0] K_VEC  = TYPE_W'(2);
  localparam logic [TYPE_W-1:0] K_CPU  = TYPE_W'(3);
  localparam logic [TYPE_W-1:0] K_DEV  = TYPE_W'(4);
  localparam logic [TYPE_W-1:0] K_SW   = TYPE_W'(5);
  localparam logic [TYPE_W-1:0] K_RERR = TYPE_W'(6);

  logic [VEC_W-1:0] pend [NUM_TYPES];
  logic [VEC_W-1:0] nxt  [NUM_TYPES];
  logic [NUM_TYPES-1:0] post_hit, clr_hit;
  logic [LVL_W-1:0] sw_lvl;

  always_comb begin
    for (int t = 0; t < NUM_TYPES; t++) begin
      post_hit[t] = post_en && (post_type == TYPE_W'(t));
      clr_hit[t]  = clr_en  && (clr_type  == TYPE_W'(t));
      nxt[t] = pend[t];
      if (clr_hit[t])  nxt[t] = nxt[t] & ~(VEC_W'(1) << clr_idx);
      if (post_hit[t]) nxt[t] = nxt[t] |  (VEC_W'(1) << post_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TYPES; t++) pend[t] <= '0;
      pend_stat <= '0;
    end else begin
      for (int t = 0; t < NUM_TYPES; t++) begin
        pend[t] <= nxt[t];
        if (post_hit[t])
          pend_stat[t] <= 1'b1;
        else if (clr_hit[t] && nxt[t] == '0)
          pend_stat[t] <= 1'b0;
      end
    end
  end

  assign rd_vec = (rd_type < TYPE_W'(NUM_TYPES)) ? pend[rd_type] : '0;

  always_comb begin
    sw_lvl = '0;
    if (pend[K_SW][0] || pend[K_SW][SW_ALIAS])
      sw_lvl = LVL_W'(SW_TOP);
    else
      for (int l = 1; l <= SW_TOP; l++)
        if (pend[K_SW][l]) sw_lvl = LVL_W'(l);
  end

  always_comb begin
    irq_valid = 1'b0;
    irq_kind  = '0;
    irq_level = '0;
    if (hpriv) begin
      if (pend_stat[K_TICK])      begin irq_valid = 1'b1; irq_kind = K_TICK; end
      else if (pend_stat[K_VEC])  begin irq_valid = 1'b1; irq_kind = K_VEC;  end
    end else begin
      if (pend_stat[K_TL0])       begin irq_valid = 1'b1; irq_kind = K_TL0;  end
      else if (pend_stat[K_TICK]) begin irq_valid = 1'b1; irq_kind = K_TICK; end
      else if (pend_stat[K_VEC])  begin irq_valid = 1'b1; irq_kind = K_VEC;  end
      else if (ie && pend_stat[K_CPU]) begin irq_valid = 1'b1; irq_kind = K_CPU; end
      else if (ie && pend_stat[K_DEV]) begin irq_valid = 1'b1; irq_kind = K_DEV; end
      else if (ie && pend_stat[K_SW] && sw_lvl != '0) begin
        irq_valid = 1'b1; irq_kind = K_SW; irq_level = sw_lvl;
      end
      else if (ie && pend_stat[K_RERR]) begin irq_valid = 1'b1; irq_kind = K_RERR; end
    end
  end

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_chk
    p_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_stat[t] == (pend[t] != '0));
    p_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
      post_en && post_type == TYPE_W'(t) |=> pend[t][$past(post_idx)] && pend_stat[t]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en && clr_type == TYPE_W'(t) && !(post_en && post_type == clr_type)
      |=> !pend[t][$past(clr_idx)]);
    p_same_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      post_en && clr_en && post_type == TYPE_W'(t) && clr_type == post_type &&
      clr_idx == post_idx |=> pend[t][$past(post_idx)]);
    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!post_en || post_type >= TYPE_W'(NUM_TYPES)) &&
      (!clr_en || clr_type >= TYPE_W'(NUM_TYPES)) |=> $stable(pend[t]));
  end

  p_hpriv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hpriv && irq_valid |-> irq_kind == K_TICK || irq_kind == K_VEC);
  p_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_stat[K_TICK] && (hpriv || !pend_stat[K_TL0]) |-> irq_valid && irq_kind == K_TICK);
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie && irq_valid |-> irq_kind <= K_VEC);
  p_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_kind == K_SW) == (irq_level != '0));
endmodule

// File: tb/intr_pend_sel_test.sv
`timescale 1ns/1ps
module intr_pend_sel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic post_en = 1'b0, clr_en = 1'b0, hpriv = 1'b0, ie = 1'b0;
  logic [2:0] post_type = '0, clr_type = '0, rd_type = '0;
  logic [5:0] post_idx = '0, clr_idx = '0;
  logic [63:0] rd_vec;
  logic [6:0] pend_stat;
  logic irq_valid;
  logic [2:0] irq_kind;
  logic [3:0] irq_level;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] m [7];

  always #2.5 clk = ~clk;

  intr_pend_sel uut (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_type(post_type), .post_idx(post_idx),
    .clr_en(clr_en), .clr_type(clr_type), .clr_idx(clr_idx), .rd_type(rd_type),
    .rd_vec(rd_vec), .pend_stat(pend_stat), .hpriv(hpriv), .ie(ie),
    .irq_valid(irq_valid), .irq_kind(irq_kind), .irq_level(irq_level));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] swlvl(logic [63:0] v);
    if (v[16] || v[0]) return 4'd14;
    for (int l = 14; l >= 1; l--) if (v[l]) return 4'(l);
    return 4'd0;
  endfunction

  function automatic logic [7:0] expsel(bit hp, bit en);
    if (hp) begin
      if (m[1] != 0) return {1'b1, 3'd1, 4'd0};
      if (m[2] != 0) return {1'b1, 3'd2, 4'd0};
      return 8'd0;
    end
    for (int t = 0; t < 3; t++) if (m[t] != 0) return {1'b1, 3'(t), 4'd0};
    if (!en) return 8'd0;
    if (m[3] != 0) return {1'b1, 3'd3, 4'd0};
    if (m[4] != 0) return {1'b1, 3'd4, 4'd0};
    if (swlvl(m[5]) != 0) return {1'b1, 3'd5, swlvl(m[5])};
    if (m[6] != 0) return {1'b1, 3'd6, 4'd0};
    return 8'd0;
  endfunction

  task automatic step(bit pe, logic [2:0] pt, logic [5:0] pi, bit ce, logic [2:0] ct,
                      logic [5:0] ci, bit hp, bit en, logic [2:0] rt);
    logic [7:0] e;
    logic [6:0] es;
    @(negedge clk);
    post_en = pe; post_type = pt; post_idx = pi;
    clr_en = ce; clr_type = ct; clr_idx = ci;
    hpriv = hp; ie = en; rd_type = rt;
    #1;
    e = expsel(hp, en);
    chk(hp ? "R6 R8" : (e[6:4] == 3'd5 ? "R10 R11" : "R7 R9 R12"),
        64'({irq_valid, irq_kind, irq_level}), 64'(e));
    chk("R2 R4 R5 rd", rd_vec, (rt < 3'd7) ? m[rt] : 64'd0);
    for (int t = 0; t < 7; t++) es[t] = (m[t] != 0);
    chk("R3 status", 64'(pend_stat), 64'(es));
    if (ce && ct < 3'd7) m[ct][ci] = 1'b0;
    if (pe && pt < 3'd7) m[pt][pi] = 1'b1;
  endtask

  task automatic nop(bit hp, bit en, logic [2:0] rt);
    step(0, 0, 0, 0, 0, 0, hp, en, rt);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] pick [8] = '{6'd0, 6'd1, 6'd3, 6'd14, 6'd15, 6'd16, 6'd40, 6'd63};
    void'($urandom(32'd4242));
    for (int t = 0; t < 7; t++) m[t] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every type
    for (int t = 0; t < 8; t++) begin
      nop(0, 1, 3'(t));
      chk("R1 reset rd", rd_vec, 64'd0);
    end
    chk("R1 reset stat", 64'(pend_stat), 64'd0);
    chk("R1 reset sel", 64'({irq_valid, irq_kind, irq_level}), 64'd0);

    // R11: bit 15 alone is not eligible; resumable error shows through
    step(1, 5, 15, 0, 0, 0, 0, 1, 5);
    step(1, 6, 2, 0, 0, 0, 0, 1, 5);
    nop(0, 1, 5);
    chk("R11 sw stat", 64'(pend_stat[5]), 64'd1);
    chk("R11 rerr wins", 64'({irq_valid, irq_kind, irq_level}), 64'({1'b1, 3'd6, 4'd0}));
    // R10: level from highest bit, alias bit 16 forces top
    step(1, 5, 3, 0, 0, 0, 0, 1, 5);
    nop(0, 1, 5);
    chk("R10 level 3", 64'(irq_level), 64'd3);
    step(1, 5, 16, 0, 0, 0, 0, 1, 5);
    nop(0, 1, 5);
    chk("R10 alias 16", 64'(irq_level), 64'd14);
    step(0, 0, 0, 1, 5, 16, 0, 1, 5);
    step(0, 0, 0, 1, 5, 3, 0, 1, 5);
    step(1, 5, 0, 0, 0, 0, 0, 1, 5);
    nop(0, 1, 5);
    chk("R10 alias 0", 64'(irq_level), 64'd14);
    // R3: status holds until the last bit is cleared
    step(0, 0, 0, 1, 5, 0, 0, 1, 5);
    nop(0, 1, 5);
    chk("R3 stat held", 64'(pend_stat[5]), 64'd1);
    step(0, 0, 0, 1, 5, 15, 0, 1, 5);
    nop(0, 1, 5);
    chk("R3 stat drop", 64'(pend_stat[5]), 64'd0);
    // R4: same bit post and clear, post wins
    step(1, 2, 7, 1, 2, 7, 0, 0, 2);
    nop(0, 0, 2);
    chk("R4 post wins", 64'(rd_vec[7]), 64'd1);
    // R5: type 7 is ignored
    step(1, 7, 9, 0, 0, 0, 0, 0, 2);
    step(0, 0, 0, 1, 7, 7, 0, 0, 2);
    for (int t = 0; t < 8; t++) nop(0, 0, 3'(t));
    // R9/R8: disabled interrupts still see the tick match
    step(1, 3, 1, 0, 0, 0, 0, 0, 1);
    step(1, 1, 4, 0, 0, 0, 1, 0, 1);
    nop(1, 0, 1);
    chk("R8 tick hpriv no ie", 64'({irq_valid, irq_kind}), 64'({1'b1, 3'd1}));
    step(1, 0, 5, 0, 0, 0, 0, 0, 0);
    nop(0, 0, 0);
    chk("R7 tl0 first", 64'({irq_valid, irq_kind}), 64'({1'b1, 3'd0}));
    nop(1, 1, 0);
    chk("R6 hpriv skips tl0", 64'({irq_valid, irq_kind}), 64'({1'b1, 3'd1}));

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 9) < 4, 3'($urandom_range(0, 7)), pick[$urandom_range(0, 7)],
           $urandom_range(0, 9) < 5, 3'($urandom_range(0, 7)), pick[$urandom_range(0, 7)],
           $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)));
    end
    nop(0, 1, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule